// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit checks a single tagged memory access. A requester hands it a 64-bit pointer, a small access descriptor and the check-fail mode fields of the active control register. The unit first decides whether the access needs a check at all. If it does, it asks an external tag store for the 4-bit tag of the addressed granule over a request/response port. It then compares that tag with the logical tag that the pointer carries in bits 59:56.

A mismatch is handled according to a 2-bit fail mode. The mode can raise a synchronous fault indication, set a sticky bit in a per-level status register, pulse an error-report strobe, or do nothing. A probe request returns only the raw pass/fail outcome and has no side effects. Each accepted request produces exactly one result strobe. The unit handles one request at a time.

Top module: `tag_check_unit`

## Requirements
- R1: The top-byte-ignore enable is `req_desc[0]` when pointer bit 55 is 0 and `req_desc[1]` when bit 55 is 1. When the selected enable is clear, the access is unchecked: no lookup is issued, `res_pass` is 1, and `res_ptr` equals the pointer unmodified.
- R2: The match-all enable is `req_desc[2]` when bit 55 is 0 and `req_desc[3]` when bit 55 is 1. When the selected enable is set and pointer bits 59:55 are all zeros or all ones, the access passes with no lookup.
- R3: A checked access issues one lookup. It carries `lk_addr` equal to the pointer, `lk_store` equal to `req_desc[4]` (1 = store) and `lk_esize` equal to `req_desc[9:5]`. `lk_valid` and `lk_addr` hold steady until `lk_ready` is seen.
- R4: A lookup response with `lk_rsp_notag` = 1 makes the access pass, whatever tag comes back.
- R5: A checked access with tag storage passes only when `lk_rsp_tag` equals pointer bits 59:56.
- R6: On a mismatch the fail mode is `req_tcf[1:0]` when `req_unpriv` = 1 and `req_tcf[3:2]` otherwise.
- R7: Fail mode 1 makes the result `res_pass` = 0 and pulses `flt_valid` in the result cycle. In that cycle `flt_code` = 0x11 and `flt_addr` is the full pointer. `flt_lvl_nz` is 1 when the faulting level is nonzero; the level is 0 for an unprivileged access and `req_el` otherwise.
- R8: Fail mode 2 passes the access and ORs one bit into `sticky_status[2*L+1:2*L]` for level L. The high bit is set when `req_two_ranges` = 1 and pointer bit 55 = 1; otherwise the low bit is set. Bits never clear except by R11.
- R9: Fail mode 3 passes the access and pulses only `err_strobe` in the result cycle. Fail mode 0 passes the access with no strobe and no status change.
- R10: With `req_probe` = 1 the result reports the raw outcome: 0 only for a checked mismatch. A probe never raises `flt_valid` or `err_strobe` and never changes `sticky_status`.
- R11: `sticky_clr[L]` clears both sticky bits of level L at the next clock edge. A sticky set at the same edge as a clear wins over the clear.
- R12: `req_ready` is high only when no request is in flight. Each accepted request produces exactly one single-cycle `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_ptr | input | 64 | Tagged pointer |
| req_desc | input | 10 | Descriptor: [1:0] top-byte-ignore enables, [3:2] match-all enables, [4] store, [9:5] element size |
| req_tcf | input | 4 | Fail-mode fields: [1:0] unprivileged, [3:2] privileged |
| req_unpriv | input | 1 | Access runs in an unprivileged regime |
| req_two_ranges | input | 1 | Regime has two address ranges |
| req_el | input | 2 | Exception level of the regime |
| req_probe | input | 1 | Non-faulting probe |
| lk_valid | output | 1 | Tag lookup request |
| lk_ready | input | 1 | Tag store accepts lookup |
| lk_addr | output | 64 | Lookup address |
| lk_store | output | 1 | Lookup is for a store |
| lk_esize | output | 5 | Element size of the access |
| lk_rsp_valid | input | 1 | Lookup response |
| lk_rsp_tag | input | 4 | Stored allocation tag |
| lk_rsp_notag | input | 1 | Address has no tag storage |
| res_valid | output | 1 | Result strobe |
| res_pass | output | 1 | Access may proceed (probe: raw outcome) |
| res_ptr | output | 64 | Pointer, unmodified |
| flt_valid | output | 1 | Synchronous tag fault strobe |
| flt_addr | output | 64 | Faulting address |
| flt_code | output | 6 | Fault status code |
| flt_lvl_nz | output | 1 | Faulting level is nonzero |
| err_strobe | output | 1 | Reserved fail mode used |
| sticky_clr | input | 4 | Per-level sticky clear |
| sticky_status | output | 8 | Sticky bits, two per level |

## Verification
Several properties are checked on every cycle. A pending lookup holds its address until it is accepted. A fault strobe always comes with a failing result. The error strobe always comes with a passing result. A probe result never comes with a side effect. Sticky bits only grow unless a clear is asserted. A result never repeats on the next cycle. Whether each bypass level picks the right enable from bit 55, the choice of fail-mode field, the placement of the sticky bit, and a clear that meets a set can be shown only by the bench scenarios, which compare every result and the sticky register against a behavioural model.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  // Pointer field positions
  localparam int TAG_W    = 4;
  localparam int TAG_LSB  = 56;
  localparam int SEL_BIT  = 55;
  // Descriptor layout
  localparam int D_TBI0   = 0;
  localparam int D_TBI1   = 1;
  localparam int D_MALL0  = 2;
  localparam int D_MALL1  = 3;
  localparam int D_STORE  = 4;
  localparam int D_ESZ_LSB = 5;
  localparam int ESZ_W    = 5;
  localparam int DESC_W   = D_ESZ_LSB + ESZ_W;
  // Fail-mode field layout
  localparam int TCF_W    = 4;
  localparam int FSC_W    = 6;
  localparam logic [FSC_W-1:0] FSC_TAG = 6'h11;

  typedef enum logic [1:0] {
    FM_IGNORE = 2'd0,
    FM_SYNC   = 2'd1,
    FM_ASYNC  = 2'd2,
    FM_RSVD   = 2'd3
  } fail_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_REQ  = 2'd2,
    ST_RSP  = 2'd3
  } tcu_state_e;

  typedef struct packed {
    logic pass;
    logic fault;
    logic sticky;
    logic err;
  } verdict_t;
endpackage

// File: rtl/tcu_bypass.sv
module tcu_bypass
  import tcu_pkg::*;
(
  input  logic [4:0]       top5,      // pointer bits 59:55
  input  logic [1:0]       tbi_en,
  input  logic [1:0]       mall_en,
  output logic             checked,
  output logic             match_all,
  output logic [TAG_W-1:0] ltag
);
  logic sel;
  logic uniform;

  always_comb begin
    sel       = top5[0];
    ltag      = top5[4:1];
    uniform   = (top5 == 5'b00000) || (top5 == 5'b11111);
    checked   = sel ? tbi_en[1] : tbi_en[0];
    match_all = (sel ? mall_en[1] : mall_en[0]) && uniform;
  end
endmodule

// File: rtl/tcu_verdict.sv
module tcu_verdict
  import tcu_pkg::*;
(
  input  logic             notag,
  input  logic [TAG_W-1:0] mtag,
  input  logic [TAG_W-1:0] ltag,
  input  logic             probe,
  input  logic             unpriv,
  input  logic [TCF_W-1:0] tcf,
  output verdict_t         v
);
  logic       match;
  fail_mode_e mode;

  always_comb begin
    match = notag || (mtag == ltag);
    mode  = fail_mode_e'(unpriv ? tcf[1:0] : tcf[3:2]);
    v     = '{pass: 1'b1, fault: 1'b0, sticky: 1'b0, err: 1'b0};
    if (probe) begin
      v.pass = match;
    end else if (!match) begin
      unique case (mode)
        FM_IGNORE: v.pass = 1'b1;
        FM_SYNC:   begin v.pass = 1'b0; v.fault = 1'b1; end
        FM_ASYNC:  v.sticky = 1'b1;
        FM_RSVD:   v.err = 1'b1;
        default:   v.pass = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tcu_sticky.sv
module tcu_sticky #(
  parameter int N_LVL = 4,
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_lvl,
  input  logic               set_hi,
  input  logic [N_LVL-1:0]   clr,
  output logic [2*N_LVL-1:0] status
);
  for (genvar gi = 0; gi < N_LVL; gi++) begin : g_lvl
    logic [1:0] q;
    logic       hit;
    assign hit = set_en && (set_lvl == LVL_W'(gi));
    always_ff @(posedge clk) begin
      if (rst) q <= 2'b00;
      else     q <= (clr[gi] ? 2'b00 : q) | (hit ? (set_hi ? 2'b10 : 2'b01) : 2'b00);
    end
    assign status[2*gi +: 2] = q;
  end
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int N_LVL = 4,
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1,
  localparam int ST_W  = 2 * N_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [TCF_W-1:0] req_tcf,
  input  logic             req_unpriv,
  input  logic             req_two_ranges,
  input  logic [LVL_W-1:0] req_el,
  input  logic             req_probe,
  output logic             lk_valid,
  input  logic             lk_ready,
  output logic [PTR_W-1:0] lk_addr,
  output logic             lk_store,
  output logic [ESZ_W-1:0] lk_esize,
  input  logic             lk_rsp_valid,
  input  logic [TAG_W-1:0] lk_rsp_tag,
  input  logic             lk_rsp_notag,
  output logic             res_valid,
  output logic             res_pass,
  output logic [PTR_W-1:0] res_ptr,
  output logic             flt_valid,
  output logic [PTR_W-1:0] flt_addr,
  output logic [FSC_W-1:0] flt_code,
  output logic             flt_lvl_nz,
  output logic             err_strobe,
  input  logic [N_LVL-1:0] sticky_clr,
  output logic [ST_W-1:0]  sticky_status
);
  tcu_state_e       st;
  logic [PTR_W-1:0] q_ptr;
  logic [1:0]       q_tbi, q_mall;
  logic             q_store;
  logic [ESZ_W-1:0] q_esz;
  logic [TCF_W-1:0] q_tcf;
  logic             q_unpriv, q_two, q_probe;
  logic [LVL_W-1:0] q_el;

  logic             checked, match_all;
  logic [TAG_W-1:0] ltag;
  verdict_t         vd;
  logic [LVL_W-1:0] eff_lvl;
  logic             rsp_fire, set_en;

  tcu_bypass u_bypass (
    .top5      (q_ptr[TAG_LSB+TAG_W-1:SEL_BIT]),
    .tbi_en    (q_tbi),
    .mall_en   (q_mall),
    .checked   (checked),
    .match_all (match_all),
    .ltag      (ltag)
  );

  tcu_verdict u_verdict (
    .notag  (lk_rsp_notag),
    .mtag   (lk_rsp_tag),
    .ltag   (ltag),
    .probe  (q_probe),
    .unpriv (q_unpriv),
    .tcf    (q_tcf),
    .v      (vd)
  );

  assign eff_lvl  = q_unpriv ? '0 : q_el;
  assign rsp_fire = (st == ST_RSP) && lk_rsp_valid;
  assign set_en   = rsp_fire && vd.sticky;

  tcu_sticky #(.N_LVL(N_LVL)) u_sticky (
    .clk     (clk),
    .rst     (rst),
    .set_en  (set_en),
    .set_lvl (eff_lvl),
    .set_hi  (q_two && q_ptr[SEL_BIT]),
    .clr     (sticky_clr),
    .status  (sticky_status)
  );

  assign req_ready = (st == ST_IDLE);
  assign lk_valid  = (st == ST_REQ);
  assign lk_addr   = q_ptr;
  assign lk_store  = q_store;
  assign lk_esize  = q_esz;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      q_ptr      <= '0;
      q_tbi      <= '0;
      q_mall     <= '0;
      q_store    <= 1'b0;
      q_esz      <= '0;
      q_tcf      <= '0;
      q_unpriv   <= 1'b0;
      q_two      <= 1'b0;
      q_probe    <= 1'b0;
      q_el       <= '0;
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_ptr    <= '0;
      flt_valid  <= 1'b0;
      flt_addr   <= '0;
      flt_code   <= '0;
      flt_lvl_nz <= 1'b0;
      err_strobe <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      flt_valid  <= 1'b0;
      err_strobe <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          q_ptr    <= req_ptr;
          q_tbi    <= {req_desc[D_TBI1], req_desc[D_TBI0]};
          q_mall   <= {req_desc[D_MALL1], req_desc[D_MALL0]};
          q_store  <= req_desc[D_STORE];
          q_esz    <= req_desc[D_ESZ_LSB +: ESZ_W];
          q_tcf    <= req_tcf;
          q_unpriv <= req_unpriv;
          q_two    <= req_two_ranges;
          q_probe  <= req_probe;
          q_el     <= req_el;
          st       <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!checked || match_all) begin
            res_valid <= 1'b1;
            res_pass  <= 1'b1;
            res_ptr   <= q_ptr;
            st        <= ST_IDLE;
          end else begin
            st <= ST_REQ;
          end
        end
        ST_REQ: if (lk_ready) st <= ST_RSP;
        ST_RSP: if (lk_rsp_valid) begin
          res_valid  <= 1'b1;
          res_pass   <= vd.pass;
          res_ptr    <= q_ptr;
          flt_valid  <= vd.fault;
          flt_addr   <= q_ptr;
          flt_code   <= vd.fault ? FSC_TAG : '0;
          flt_lvl_nz <= (eff_lvl != '0);
          err_strobe <= vd.err;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int PTR_W = 64,
  parameter int ST_W  = 8,
  parameter int N_LVL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [PTR_W-1:0] lk_addr,
  input logic             res_valid,
  input logic             res_pass,
  input logic             flt_valid,
  input logic             err_strobe,
  input logic             q_probe,
  input logic [N_LVL-1:0] sticky_clr,
  input logic [ST_W-1:0]  sticky_status
);
  a_r3_lookup_hold: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !lk_ready |=> lk_valid && $stable(lk_addr));

  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> !req_ready);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r7_fault_fails: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> res_valid && !res_pass);

  a_r9_err_passes: assert property (@(posedge clk) disable iff (rst)
    err_strobe |-> res_valid && res_pass && !flt_valid);

  a_r10_probe_quiet: assert property (@(posedge clk) disable iff (rst)
    res_valid && q_probe |-> !flt_valid && !err_strobe);

  a_r8_sticky_grows: assert property (@(posedge clk) disable iff (rst)
    sticky_clr == '0 |=> (sticky_status & $past(sticky_status)) == $past(sticky_status));
endmodule

bind tag_check_unit tcu_checker #(.PTR_W(PTR_W), .ST_W(ST_W), .N_LVL(N_LVL)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_ready     (req_ready),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .lk_addr       (lk_addr),
  .res_valid     (res_valid),
  .res_pass      (res_pass),
  .flt_valid     (flt_valid),
  .err_strobe    (err_strobe),
  .q_probe       (q_probe),
  .sticky_clr    (sticky_clr),
  .sticky_status (sticky_status)
);

// File: tb/tb_tag_check_unit.sv
`timescale 1ns/1ps
module tb_tag_check_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_ptr;
  logic [9:0]  req_desc;
  logic [3:0]  req_tcf;
  logic        req_unpriv, req_two_ranges, req_probe;
  logic [1:0]  req_el;
  logic        lk_valid, lk_ready, lk_store;
  logic [63:0] lk_addr;
  logic [4:0]  lk_esize;
  logic        lk_rsp_valid, lk_rsp_notag;
  logic [3:0]  lk_rsp_tag;
  logic        res_valid, res_pass, flt_valid, flt_lvl_nz, err_strobe;
  logic [63:0] res_ptr, flt_addr;
  logic [5:0]  flt_code;
  logic [3:0]  sticky_clr;
  logic [7:0]  sticky_status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // responder state and behavioural model
  int          rsp_lat = 0;
  logic [3:0]  mem_tag = 4'h0;
  bit          mem_notag = 0;
  int          lk_count = 0;
  logic [63:0] cap_addr;
  logic        cap_store;
  logic [4:0]  cap_esz;
  logic [7:0]  mdl_st = 8'h00;

  always #10 clk = ~clk;

  tag_check_unit dut (.*);

  task automatic chk(input bit ok, input string r, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, a, e);
    end
  endtask

  // tag store model
  initial begin
    lk_ready = 1'b0; lk_rsp_valid = 1'b0; lk_rsp_tag = 4'h0; lk_rsp_notag = 1'b0;
    forever begin
      @(negedge clk);
      lk_rsp_valid = 1'b0;
      if (lk_valid && !lk_ready) begin
        repeat (rsp_lat) @(negedge clk);
        lk_ready  = 1'b1;
        cap_addr  = lk_addr;
        cap_store = lk_store;
        cap_esz   = lk_esize;
        @(negedge clk);
        lk_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        lk_rsp_valid = 1'b1;
        lk_rsp_tag   = mem_tag;
        lk_rsp_notag = mem_notag;
        lk_count++;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      #1;
      chk(sticky_status === mdl_st, "R8/R11 sticky", {56'h0, sticky_status}, {56'h0, mdl_st});
      chk(!(flt_valid && !res_valid), "R7 stray fault", {63'h0, flt_valid}, 64'h0);
      chk(!(err_strobe && !res_valid), "R9 stray err", {63'h0, err_strobe}, 64'h0);
    end
  end

  function automatic logic [9:0] mkd(input logic [1:0] tbi, input logic [1:0] mall,
                                     input logic st, input logic [4:0] esz);
    return {esz, st, mall, tbi};
  endfunction

  function automatic logic [63:0] mkp(input logic [3:0] tag, input logic b55, input logic [54:0] lo);
    return {4'hA, tag, b55, lo};
  endfunction

  task automatic run(input string nm, input logic [63:0] p, input logic [9:0] d,
                     input logic [3:0] tcf, input bit unp, input bit two,
                     input logic [1:0] el, input bit prb, input logic [3:0] mt, input bit nt);
    bit sel, chkd, mall, lookup, match, e_pass, e_flt, e_err, e_st, got;
    logic [1:0] mode, lvl;
    logic [4:0] top;
    int c0;
    sel    = p[55];
    top    = p[59:55];
    chkd   = d[sel];
    mall   = d[2 + sel] && (top == 5'h00 || top == 5'h1f);
    lookup = chkd && !mall;
    match  = nt || (mt == p[59:56]);
    mode   = unp ? tcf[1:0] : tcf[3:2];
    lvl    = unp ? 2'd0 : el;
    e_pass = 1; e_flt = 0; e_err = 0; e_st = 0;
    if (lookup && !match) begin
      if (prb) e_pass = 0;
      else case (mode)
        2'd1: begin e_pass = 0; e_flt = 1; end
        2'd2: e_st = 1;
        2'd3: e_err = 1;
        default: ;
      endcase
    end
    mem_tag = mt; mem_notag = nt;
    c0 = lk_count;
    @(negedge clk);
    req_ptr = p; req_desc = d; req_tcf = tcf; req_unpriv = unp;
    req_two_ranges = two; req_el = el; req_probe = prb; req_valid = 1'b1;
    chk(req_ready === 1'b1, {"R12 ready idle ", nm}, {63'h0, req_ready}, 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, {"R12 busy ", nm}, {63'h0, req_ready}, 64'h0);
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (i > 0) @(negedge clk);
      if (res_valid) got = 1;
    end
    chk(got, {"R12 result ", nm}, {63'h0, got}, 64'h1);
    if (got) begin
      if (e_st) mdl_st[2*lvl + ((two && sel) ? 1 : 0)] = 1'b1;
      sticky_clr = 4'h0;
      chk(res_pass === e_pass, {"R5 pass ", nm}, {63'h0, res_pass}, {63'h0, e_pass});
      chk(res_ptr === p, {"R1 ptr ", nm}, res_ptr, p);
      chk(flt_valid === e_flt, {"R7 fault ", nm}, {63'h0, flt_valid}, {63'h0, e_flt});
      chk(err_strobe === e_err, {"R9 err ", nm}, {63'h0, err_strobe}, {63'h0, e_err});
      if (e_flt) begin
        chk(flt_code === 6'h11, {"R7 code ", nm}, {58'h0, flt_code}, 64'h11);
        chk(flt_addr === p, {"R7 addr ", nm}, flt_addr, p);
        chk(flt_lvl_nz === (lvl != 0), {"R7 lvl ", nm}, {63'h0, flt_lvl_nz}, {63'h0, lvl != 0});
      end
      chk((lk_count - c0) == (lookup ? 1 : 0), {"R2 lookups ", nm},
          64'(lk_count - c0), {63'h0, lookup});
      if (lookup) begin
        chk(cap_addr === p, {"R3 addr ", nm}, cap_addr, p);
        chk(cap_store === d[4], {"R3 store ", nm}, {63'h0, cap_store}, {63'h0, d[4]});
        chk(cap_esz === d[9:5], {"R3 esize ", nm}, {59'h0, cap_esz}, {59'h0, d[9:5]});
      end
      @(negedge clk);
      chk(res_valid === 1'b0, {"R12 single pulse ", nm}, {63'h0, res_valid}, 64'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_ptr = '0; req_desc = '0; req_tcf = '0;
    req_unpriv = 1'b0; req_two_ranges = 1'b0; req_el = '0; req_probe = 1'b0; sticky_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R12 reset ready", {63'h0, req_ready}, 64'h1);
    chk(res_valid === 1'b0 && lk_valid === 1'b0, "R12 reset idle", {62'h0, res_valid, lk_valid}, 64'h0);
    chk(sticky_status === 8'h00, "R11 reset sticky", {56'h0, sticky_status}, 64'h0);

    // R1: unchecked by selected enable, even with a mismatch in sync mode
    run("r1_low",  mkp(4'h3, 1'b0, 55'h123), mkd(2'b10, 2'b00, 1'b0, 5'h2), 4'h5, 0, 0, 2'd1, 0, 4'h9, 0);
    run("r1_high", mkp(4'h3, 1'b1, 55'h456), mkd(2'b01, 2'b00, 1'b0, 5'h2), 4'h5, 0, 0, 2'd1, 0, 4'h9, 0);
    // R2: match-all zeros / ones, and a non-uniform pattern that still looks up
    run("r2_zero", mkp(4'h0, 1'b0, 55'h10), mkd(2'b11, 2'b01, 1'b0, 5'h3), 4'h5, 0, 0, 2'd1, 0, 4'h7, 0);
    run("r2_ones", mkp(4'hF, 1'b1, 55'h20), mkd(2'b11, 2'b10, 1'b0, 5'h3), 4'h5, 0, 0, 2'd1, 0, 4'h7, 0);
    run("r2_mixed", mkp(4'h0, 1'b1, 55'h30), mkd(2'b11, 2'b11, 1'b1, 5'h4), 4'h5, 0, 0, 2'd1, 0, 4'h0, 0);
    run("r2_wrong_half", mkp(4'h0, 1'b0, 55'h40), mkd(2'b11, 2'b10, 1'b0, 5'h1), 4'h5, 0, 0, 2'd1, 0, 4'h0, 0);
    // R4: no tag storage
    rsp_lat = 2;
    run("r4_notag", mkp(4'h6, 1'b0, 55'h50), mkd(2'b11, 2'b00, 1'b0, 5'h0), 4'h5, 0, 0, 2'd1, 0, 4'h1, 1);
    // R5: match, store, odd size
    run("r5_match", mkp(4'hC, 1'b1, 55'h60), mkd(2'b11, 2'b00, 1'b1, 5'h13), 4'h5, 0, 0, 2'd1, 0, 4'hC, 0);
    rsp_lat = 0;
    // R6 / R7: field choice and level flag
    run("r7_unpriv", mkp(4'h2, 1'b0, 55'h70), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0001, 1, 0, 2'd2, 0, 4'h5, 0);
    run("r7_priv", mkp(4'h2, 1'b0, 55'h80), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0100, 0, 0, 2'd1, 0, 4'h5, 0);
    run("r6_priv_ignore", mkp(4'h2, 1'b0, 55'h90), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0001, 0, 0, 2'd1, 0, 4'h5, 0);
    run("r6_unpriv_ignore", mkp(4'h2, 1'b0, 55'h91), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0100, 1, 0, 2'd1, 0, 4'h5, 0);
    // R8: sticky placement and accumulation
    run("r8_hi", mkp(4'h4, 1'b1, 55'hA0), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1000, 0, 1, 2'd2, 0, 4'h1, 0);
    run("r8_lo_one_range", mkp(4'h4, 1'b1, 55'hA1), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1000, 0, 0, 2'd2, 0, 4'h1, 0);
    run("r8_unpriv_lvl0", mkp(4'h4, 1'b0, 55'hA2), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0010, 1, 1, 2'd3, 0, 4'h1, 0);
    run("r8_lvl1", mkp(4'h4, 1'b0, 55'hA3), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1000, 0, 1, 2'd1, 0, 4'h1, 0);
    // R9: reserved and ignore modes
    run("r9_rsvd", mkp(4'h8, 1'b0, 55'hB0), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1100, 0, 0, 2'd1, 0, 4'h1, 0);
    run("r9_ignore", mkp(4'h8, 1'b0, 55'hB1), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0000, 0, 0, 2'd1, 0, 4'h1, 0);
    // R10: probe
    run("r10_mismatch", mkp(4'h8, 1'b1, 55'hC0), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b0100, 0, 1, 2'd1, 1, 4'h1, 0);
    run("r10_async", mkp(4'h8, 1'b1, 55'hC1), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1000, 0, 1, 2'd3, 1, 4'h1, 0);
    run("r10_unchecked", mkp(4'h8, 1'b1, 55'hC2), mkd(2'b01, 2'b00, 1'b0, 5'h2), 4'b0100, 0, 1, 2'd1, 1, 4'h1, 0);
    // R11: plain clear of level 2
    @(negedge clk); sticky_clr = 4'b0100;
    @(negedge clk); mdl_st[5:4] = 2'b00; sticky_clr = 4'h0;
    @(negedge clk);
    chk(sticky_status[5:4] === 2'b00, "R11 clear lvl2", {62'h0, sticky_status[5:4]}, 64'h0);
    // R11: clear held across a set on level 1, set wins on the same edge
    @(negedge clk); sticky_clr = 4'b0010;
    @(negedge clk); mdl_st[3:2] = 2'b00;
    run("r11_set_wins", mkp(4'h4, 1'b1, 55'hD0), mkd(2'b11, 2'b00, 1'b0, 5'h2), 4'b1000, 0, 1, 2'd1, 0, 4'h1, 0);
    chk(sticky_status[3:2] === 2'b10, "R11 set over clear", {62'h0, sticky_status[3:2]}, 64'h2);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule